// File: doc/BRIEF.md
# Board Control Register Block

A small peripheral for an FPGA evaluation board. It sits on a simple 32-bit register bus and occupies a 64 KiB address window. Registers are selected by byte offset within that window. Two registers are fixed identification constants: a build-date word and the processor clock rate in hertz. A third register drives the board LEDs and can be read back. A fourth register is read-only and returns the DIP switch inputs. The switch inputs pass through a reset-cleared synchronizer before they can be read.

A write-only control offset asks the board for a system reset. It does so only when one exact magic value is written there. The request leaves the block as a one-cycle pulse, and logic outside the block carries out the reset.

Each bus access takes one cycle and is marked by a valid strobe. The address is a word address: its two lowest bits are not decoded. Read data is registered and appears on the cycle after the request.

Top module: `brd_ctl_regs`

## Requirements
- R1: A read at byte offset 0x0 returns the build identifier ID_CODE (default 0x09272011).
- R2: A read at byte offset 0x4 returns the processor clock rate CLK_HZ in hertz (default 10000000, which is 0x00989680).
- R3: A write at byte offset 0x8 loads the LED register, and `led_out` shows the new value from the cycle after the write. A 1 bit turns an LED on. A read at 0x8 returns the register value, zero-extended.
- R4: While reset is active, `led_out`, `rsp_rdata` and `board_rst_req` are all zero, and the switch synchronizer stages clear to zero.
- R5: A read at byte offset 0xC returns `sw_in`, zero-extended, after two synchronizer stages. A new switch value that is set before clock edge t is returned by a read sampled at edge t+2 or later. A read sampled at edge t or t+1 returns the previous value.
- R6: A write at byte offset 0xC changes neither the switch read-back value nor `led_out`.
- R7: A write of exactly 0x0000DEAD at byte offset 0x10 drives `board_rst_req` high for the single cycle that follows the write. Each qualifying write produces its own pulse.
- R8: A write of any other value at byte offset 0x10 leaves `board_rst_req` low.
- R9: A read at any offset other than 0x0, 0x4, 0x8 and 0xC returns zero. This includes 0x10 and the top of the window.
- R10: A write at any offset other than 0x8 and 0x10 changes neither `led_out` nor `board_rst_req`.
- R11: `rsp_rdata` is valid on the cycle after a read request, and it is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access strobe, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte offset within the window; bits 1:0 are ignored |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Registered read data |
| led_out | output | LED_W (32) | LED drive, 1 = on |
| sw_in | input | SW_W (8) | Asynchronous DIP switch inputs, 1 = on |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose.

The first pair is a switch read issued in the same cycle that `sw_in` changes. The bench expects the old value for that read and for the next one, and the new value only from the third read. This is judged against the two-stage latency stated in R5.

The second pair is the magic write followed at once by an LED write. In that case the reset pulse and the LED update land in the same cycle, and the bench checks both outputs together. It also checks that a back-to-back pair of magic writes yields a pulse two cycles long.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

   // Byte offsets; software depends on these values.
   localparam int unsigned OFS_ID   = 32'h0000_0000;
   localparam int unsigned OFS_RATE = 32'h0000_0004;
   localparam int unsigned OFS_LED  = 32'h0000_0008;
   localparam int unsigned OFS_SW   = 32'h0000_000C;
   localparam int unsigned OFS_KICK = 32'h0000_0010;

   localparam logic [31:0] KICK_MAGIC = 32'h0000_DEAD;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_ID   = 3'd1,
      SRC_RATE = 3'd2,
      SRC_LED  = 3'd3,
      SRC_SW   = 3'd4
   } bc_src_e;

   typedef struct packed {
      logic led;
      logic kick;
   } bc_wsel_t;

endpackage

// File: rtl/brd_ctl_decode.sv
module brd_ctl_decode
   import brd_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   output bc_wsel_t          wr_sel,
   output bc_src_e           rd_src
);

   localparam int unsigned WA_W = ADDR_W - 2;

   logic [WA_W-1:0] word_ix;
   logic            rd_req;
   logic            wr_req;

   assign word_ix = req_addr[ADDR_W-1:2];
   assign rd_req  = req_vld && !req_wr;
   assign wr_req  = req_vld && req_wr;

   always_comb begin
      rd_src = SRC_NONE;
      if (rd_req) begin
         case (word_ix)
            WA_W'(OFS_ID   >> 2): rd_src = SRC_ID;
            WA_W'(OFS_RATE >> 2): rd_src = SRC_RATE;
            WA_W'(OFS_LED  >> 2): rd_src = SRC_LED;
            WA_W'(OFS_SW   >> 2): rd_src = SRC_SW;
            default:              rd_src = SRC_NONE;
         endcase
      end
   end

   always_comb begin
      wr_sel      = '0;
      wr_sel.led  = wr_req && (word_ix == WA_W'(OFS_LED  >> 2));
      wr_sel.kick = wr_req && (word_ix == WA_W'(OFS_KICK >> 2));
   end

endmodule

// File: rtl/brd_ctl_sync.sv
module brd_ctl_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/brd_ctl_led.sv
module brd_ctl_led #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/brd_ctl_kick.sv
module brd_ctl_kick #(
   parameter int unsigned  DATA_W = 32,
   parameter logic [31:0]  MAGIC  = 32'h0000_DEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              pulse
);

   logic match;
   assign match = (wdata == DATA_W'(MAGIC));

   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= hit && match;
   end

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
   import brd_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LED_W       = 32,
   parameter int unsigned SW_W        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] ID_CODE     = 32'h0927_2011,
   parameter logic [31:0] CLK_HZ      = 32'd10_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [LED_W-1:0]  led_out,
   input  logic [SW_W-1:0]   sw_in,
   output logic              board_rst_req
);

   generate
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 5..32");
      end
      if (DATA_W != 32) begin : g_bad_data
         $error("DATA_W must be 32");
      end
      if (LED_W < 1 || LED_W > DATA_W) begin : g_bad_led
         $error("LED_W must lie in 1..DATA_W");
      end
      if (SW_W < 1 || SW_W > DATA_W) begin : g_bad_sw
         $error("SW_W must lie in 1..DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   bc_wsel_t          wr_sel;
   bc_src_e           rd_src;
   logic [SW_W-1:0]   sw_q;
   logic [DATA_W-1:0] led_ext;
   logic [DATA_W-1:0] sw_ext;
   logic [DATA_W-1:0] rd_next;

   brd_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .req_vld (req_vld),
      .req_wr  (req_wr),
      .req_addr(req_addr),
      .wr_sel  (wr_sel),
      .rd_src  (rd_src)
   );

   brd_ctl_led #(.W(LED_W)) u_led (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_sel.led),
      .wdata(req_wdata[LED_W-1:0]),
      .q    (led_out)
   );

   brd_ctl_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sw_in),
      .q    (sw_q)
   );

   brd_ctl_kick #(.DATA_W(DATA_W), .MAGIC(KICK_MAGIC)) u_kick (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (wr_sel.kick),
      .wdata(req_wdata),
      .pulse(board_rst_req)
   );

   generate
      if (LED_W == DATA_W) begin : g_led_full
         assign led_ext = led_out;
      end else begin : g_led_pad
         assign led_ext = {{(DATA_W-LED_W){1'b0}}, led_out};
      end
      if (SW_W == DATA_W) begin : g_sw_full
         assign sw_ext = sw_q;
      end else begin : g_sw_pad
         assign sw_ext = {{(DATA_W-SW_W){1'b0}}, sw_q};
      end
   endgenerate

   always_comb begin
      case (rd_src)
         SRC_ID:   rd_next = DATA_W'(ID_CODE);
         SRC_RATE: rd_next = DATA_W'(CLK_HZ);
         SRC_LED:  rd_next = led_ext;
         SRC_SW:   rd_next = sw_ext;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_rdata <= '0;
      else        rsp_rdata <= rd_next;
   end

endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk
   import brd_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned LED_W   = 32,
   parameter logic [31:0] ID_CODE = 32'h0927_2011,
   parameter logic [31:0] CLK_HZ  = 32'd10_000_000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [LED_W-1:0]  led_out,
   input logic              board_rst_req
);

   localparam int unsigned WA_W = ADDR_W - 2;

   logic [WA_W-1:0] wa;
   logic            is_rd;
   logic            is_wr;
   logic            magic_wr;

   assign wa       = req_addr[ADDR_W-1:2];
   assign is_rd    = req_vld && !req_wr;
   assign is_wr    = req_vld && req_wr;
   assign magic_wr = is_wr && (wa == WA_W'(OFS_KICK >> 2))
                     && (req_wdata == DATA_W'(KICK_MAGIC));

   // R1
   p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && wa == WA_W'(OFS_ID >> 2)) |=> (rsp_rdata == DATA_W'(ID_CODE)));

   // R2
   p_rate_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && wa == WA_W'(OFS_RATE >> 2)) |=> (rsp_rdata == DATA_W'(CLK_HZ)));

   // R3
   p_led_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && wa == WA_W'(OFS_LED >> 2)) |=> (led_out == $past(req_wdata[LED_W-1:0])));

   // R6, R10
   p_led_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_wr && wa == WA_W'(OFS_LED >> 2)) |=> $stable(led_out));

   // R7
   p_kick_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
      magic_wr |=> board_rst_req);

   // R8, R10
   p_kick_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !magic_wr |=> !board_rst_req);

   // R9
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && wa > WA_W'(OFS_SW >> 2)) |=> (rsp_rdata == '0));

   // R11
   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> (rsp_rdata == '0));

endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LED_W  (LED_W),
   .ID_CODE(ID_CODE),
   .CLK_HZ (CLK_HZ)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_vld      (req_vld),
   .req_wr       (req_wr),
   .req_addr     (req_addr),
   .req_wdata    (req_wdata),
   .rsp_rdata    (rsp_rdata),
   .led_out      (led_out),
   .board_rst_req(board_rst_req)
);

// File: tb/tb_brd_ctl_regs.sv
module tb_brd_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic        req_wr = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic [31:0] led_out;
   logic [7:0]  sw_in = '0;
   logic        board_rst_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   brd_ctl_regs dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_vld      (req_vld),
      .req_wr       (req_wr),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .rsp_rdata    (rsp_rdata),
      .led_out      (led_out),
      .sw_in        (sw_in),
      .board_rst_req(board_rst_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = a; req_wdata = '0;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic rd_sw_change(input logic [7:0] nsw, input logic [31:0] exp,
                               input string tag);
      @(negedge clk);
      sw_in = nsw;
      req_vld = 1'b1; req_wr = 1'b0; req_addr = 16'h000C; req_wdata = '0;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
   endtask

   // Monitor: pops the expected read result after each read request.
   always @(posedge clk) begin
      logic was_rd;
      was_rd = rst_n && req_vld && !req_wr;
      #2;
      if (was_rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected read", rsp_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rsp_rdata === e, t, rsp_rdata, e);
         end
      end else if (rst_n && rsp_rdata !== 32'h0) begin
         chk(1'b0, "R11 idle data", rsp_rdata, 32'h0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R4: reset state
      chk(led_out === 32'h0, "R4 led", led_out, 32'h0);
      chk(rsp_rdata === 32'h0, "R4 rdata", rsp_rdata, 32'h0);
      chk(board_rst_req === 1'b0, "R4 rst_req", {31'h0, board_rst_req}, 32'h0);
      rst_n = 1'b1;

      rd(16'h000C, 32'h0, "R4 sync clear");
      rd(16'h0000, 32'h0927_2011, "R1 id");
      rd(16'h0004, 32'd10_000_000, "R2 rate");
      rd(16'h0008, 32'h0, "R3 led after reset");
      idle();

      // R3: LED write and read-back
      wr(16'h0008, 32'hA5A5_0F0F);
      idle();
      chk(led_out === 32'hA5A5_0F0F, "R3 led_out", led_out, 32'hA5A5_0F0F);
      rd(16'h0008, 32'hA5A5_0F0F, "R3 read back");
      wr(16'h0008, 32'h0000_0001);
      rd(16'h0008, 32'h0000_0001, "R3 second pattern");
      idle();

      // R5: switch sampling
      @(negedge clk); sw_in = 8'h5A;
      idle();
      rd(16'h000C, 32'h0000_005A, "R5 switches");
      // R6: write to switch offset ignored
      wr(16'h000C, 32'hFFFF_FFFF);
      idle();
      chk(led_out === 32'h1, "R6 led untouched", led_out, 32'h1);
      rd(16'h000C, 32'h0000_005A, "R6 switches unchanged");

      // R5: change lands in the same cycle as a read
      rd_sw_change(8'hC3, 32'h0000_005A, "R5 same-cycle old");
      rd(16'h000C, 32'h0000_005A, "R5 one cycle later old");
      rd(16'h000C, 32'h0000_00C3, "R5 two cycles later new");
      idle();

      // R9: unmapped reads
      rd(16'h0010, 32'h0, "R9 kick offset");
      rd(16'h0014, 32'h0, "R9 0x14");
      rd(16'hFFFC, 32'h0, "R9 window top");
      idle();

      // R8: wrong value at kick offset
      wr(16'h0010, 32'h0001_DEAD);
      idle();
      chk(board_rst_req === 1'b0, "R8 no pulse", {31'h0, board_rst_req}, 32'h0);
      wr(16'h0010, 32'h0000_DEAC);
      idle();
      chk(board_rst_req === 1'b0, "R8 no pulse 2", {31'h0, board_rst_req}, 32'h0);

      // R10: other writes have no effect
      wr(16'h0000, 32'h1234_5678);
      wr(16'h0004, 32'h0000_DEAD);
      wr(16'h0014, 32'h0000_DEAD);
      idle();
      chk(led_out === 32'h1, "R10 led", led_out, 32'h1);
      chk(board_rst_req === 1'b0, "R10 no pulse", {31'h0, board_rst_req}, 32'h0);
      rd(16'h0000, 32'h0927_2011, "R10 id intact");
      idle();

      // R7: magic write, then LED write in the next cycle
      wr(16'h0010, 32'h0000_DEAD);
      wr(16'h0008, 32'h0000_00F0);
      chk(board_rst_req === 1'b1, "R7 pulse", {31'h0, board_rst_req}, 32'h1);
      idle();
      chk(board_rst_req === 1'b0, "R7 pulse ends", {31'h0, board_rst_req}, 32'h0);
      chk(led_out === 32'h0000_00F0, "R3 led with pulse", led_out, 32'hF0);

      // R7: back-to-back magic writes
      wr(16'h0010, 32'h0000_DEAD);
      wr(16'h0010, 32'h0000_DEAD);
      chk(board_rst_req === 1'b1, "R7 first", {31'h0, board_rst_req}, 32'h1);
      idle();
      chk(board_rst_req === 1'b1, "R7 second", {31'h0, board_rst_req}, 32'h1);
      idle();
      chk(board_rst_req === 1'b0, "R7 low", {31'h0, board_rst_req}, 32'h0);

      idle();
      idle();
      chk(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule